// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Slave Mode)

This block sends one 16-bit left sample and one 16-bit right sample per frame on a single serial data line. An external master drives the bit clock and the word clock. The block never generates either clock. Both clocks are brought into the block's own fast clock domain, and their edges are found there. The data line is updated after each falling edge of the bit clock. A static format input chooses the framing. Low selects left-justified framing, where a high word clock marks the left channel and the MSB sits in the first bit slot. High selects I2S framing, where a low word clock marks the left channel and the MSB comes one bit slot after the word-clock edge.

The two parallel samples are captured together at the start of each left half-frame. A sample therefore never changes in the middle of a word. The block counts bit-clock rising edges between left-channel starts and judges each frame length against the ratios allowed for the selected format and system-clock ratio. When the frame just ended had a length that is not allowed, the whole next frame is sent as zero. A mute input, taken at every channel boundary, also forces zero data for that channel.

Top module: `stereo_ser_tx`

## Requirements
- R1: With `fmt_i2s_i`=0, the word clock high selects the left channel. Bit slot 0 of a half-frame (the bit period that begins at the word-clock edge) carries sample bit 15, and slots 1..15 carry bits 14..0 in order.
- R2: With `fmt_i2s_i`=1, the word clock low selects the left channel. Slot 0 carries 0, and slots 1..16 carry sample bits 15..0 in order.
- R3: Every slot of a half-frame outside the data slots named in R1/R2 carries 0.
- R4: `sdo_o` changes only in response to a bit-clock falling edge or a word-clock edge. It is stable while the bit clock is high.
- R5: `ratio_ok_o` is updated at each left-channel start. It is 1 when the frame that just ended had an allowed length:
  - 64 bit clocks in either format;
  - 48 bit clocks only when `clk384_i`=1;
  - 32 bit clocks only when `fmt_i2s_i`=0.
- R6: When `ratio_ok_o` is 0 at a left-channel start, both channels of that frame carry all-zero data. Normal data returns in the frame that follows one allowed frame.
- R7: `mute_i` is sampled at each channel boundary and forces the whole of that channel's half-frame to zero. A change in the middle of a channel takes effect only from the next boundary.
- R8: `left_i` and `right_i` are captured together at the left-channel start. Changes later in the frame do not alter the bits sent in that frame.
- R9: While and after reset, before any frame, `sdo_o` is 0 and `ratio_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Bit clock from the external master |
| wck_i | input | 1 | Word clock from the external master |
| fmt_i2s_i | input | 1 | Static framing select: 0 left-justified, 1 I2S |
| clk384_i | input | 1 | 1 when the system clock runs at 384 times the sample rate |
| mute_i | input | 1 | Request to send zero data, taken at channel boundaries |
| left_i | input | 16 | Parallel left sample |
| right_i | input | 16 | Parallel right sample |
| sdo_o | output | 1 | Serial data output |
| ratio_ok_o | output | 1 | Length of the previous frame was allowed |

## Verification
The assertions check four things on every cycle:
- the data line is zero while a channel is forced quiet;
- the data line is zero in slots past the data window;
- the data line moves only after a clock event;
- the holding registers and the ratio flag change only at a left-channel start.

The exact bit order of each format is shown only by the bench's frame scenarios. So are the acceptance of each frame ratio and recovery after a bad frame. The same goes for mute taking effect at the next boundary and sample capture that is immune to mid-frame input changes.

// File: rtl/stser_pkg.sv
package stser_pkg;
  localparam int SMP_W  = 16;
  localparam int SLOT_W = 6;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  // Serial bit carried in a half-frame slot, for either framing.
  function automatic logic slot_bit(input logic i2s, input logic [SLOT_W-1:0] slot,
                                    input logic [SMP_W-1:0] word);
    int pos;
    pos = i2s ? (int'(slot) - 1) : int'(slot);
    if (pos >= 0 && pos < SMP_W) return word[SMP_W-1-pos];
    return 1'b0;
  endfunction

  // Frame length (bit clocks per word-clock period) acceptance.
  function automatic logic ratio_accept(input logic i2s, input logic sys384,
                                        input int unsigned len);
    case (len)
      64:      return 1'b1;
      48:      return sys384;
      32:      return !i2s;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/stser_edge_det.sv
module stser_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], sig_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/stser_frame_mon.sv
module stser_frame_mon #(
  parameter int FCNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_rise_i,
  input  logic left_start_i,
  input  logic i2s_i,
  input  logic sys384_i,
  output logic ok_now_o,
  output logic ok_q_o
);
  import stser_pkg::*;
  localparam logic [FCNT_W-1:0] CNT_MAX = '1;

  logic [FCNT_W-1:0] cnt_q;
  logic seen_q, ok_q;

  assign ok_now_o = seen_q && ratio_accept(i2s_i, sys384_i, int'(cnt_q));
  assign ok_q_o   = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (left_start_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
      ok_q   <= ok_now_o;
    end else if (bck_rise_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_OK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q != $past(ok_q)) |-> $past(left_start_i)); // R5
endmodule

// File: rtl/stser_shifter.sv
module stser_shifter (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_i,
  input  logic bck_fall_i,
  input  logic wck_edge_i,
  input  logic left_start_i,
  input  logic ok_now_i,
  input  logic ok_q_i,
  input  logic mute_i,
  input  logic [stser_pkg::SMP_W-1:0] left_i,
  input  logic [stser_pkg::SMP_W-1:0] right_i,
  output logic sdo_o
);
  import stser_pkg::*;

  logic [SMP_W-1:0]  hold_l, hold_r, word_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic chan_q, chan_d, zero_q, zero_d, sdo_q;
  logic upd_evt;

  assign upd_evt = wck_edge_i | bck_fall_i;

  always_comb begin
    slot_d = slot_q;
    chan_d = chan_q;
    zero_d = zero_q;
    if (wck_edge_i) begin
      slot_d = '0;
      chan_d = !left_start_i;
      zero_d = mute_i | !(left_start_i ? ok_now_i : ok_q_i);
    end else if (bck_fall_i && slot_q != SLOT_MAX) begin
      slot_d = slot_q + 1'b1;
    end
    if (chan_d)            word_d = hold_r;
    else if (left_start_i) word_d = left_i;
    else                   word_d = hold_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      slot_q <= SLOT_MAX;
      chan_q <= 1'b0;
      zero_q <= 1'b1;
      sdo_q  <= 1'b0;
    end else begin
      if (left_start_i) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (upd_evt) begin
        slot_q <= slot_d;
        chan_q <= chan_d;
        zero_q <= zero_d;
        sdo_q  <= !zero_d && slot_bit(i2s_i, slot_d, word_d);
      end
    end
  end

  assign sdo_o = sdo_q;

  AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> !sdo_o); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q > SLOT_W'(SMP_W)) |-> !sdo_o); // R3
  AST_SDO_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_q != $past(sdo_q)) |-> $past(upd_evt)); // R4
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !left_start_i |=> ($stable(hold_l) && $stable(hold_r))); // R8
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int SYNC_STAGES = 2,
  parameter int FCNT_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic wck_i,
  input  logic fmt_i2s_i,
  input  logic clk384_i,
  input  logic mute_i,
  input  logic [15:0] left_i,
  input  logic [15:0] right_i,
  output logic sdo_o,
  output logic ratio_ok_o
);
  logic bck_rise, bck_fall, wck_rise, wck_fall;
  logic wck_edge, left_start, ok_now, ok_q;

  stser_edge_det #(.STAGES(SYNC_STAGES)) u_bck_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(bck_i), .rise_o(bck_rise), .fall_o(bck_fall));
  stser_edge_det #(.STAGES(SYNC_STAGES)) u_wck_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(wck_i), .rise_o(wck_rise), .fall_o(wck_fall));

  assign wck_edge   = wck_rise | wck_fall;
  assign left_start = fmt_i2s_i ? wck_fall : wck_rise;

  stser_frame_mon #(.FCNT_W(FCNT_W)) u_frame_mon (
    .clk(clk), .rst_n(rst_n), .bck_rise_i(bck_rise), .left_start_i(left_start),
    .i2s_i(fmt_i2s_i), .sys384_i(clk384_i), .ok_now_o(ok_now), .ok_q_o(ok_q));

  stser_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .i2s_i(fmt_i2s_i), .bck_fall_i(bck_fall),
    .wck_edge_i(wck_edge), .left_start_i(left_start), .ok_now_i(ok_now),
    .ok_q_i(ok_q), .mute_i(mute_i), .left_i(left_i), .right_i(right_i),
    .sdo_o(sdo_o));

  assign ratio_ok_o = ok_q;
endmodule

// File: tb/stereo_ser_tx_tb.sv
module stereo_ser_tx_tb_top;
  localparam int HALF_BCK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b1, wck = 1'b0, fmt = 1'b0, c384 = 1'b0, mute = 1'b0;
  logic [15:0] lin = '0, rin = '0;
  logic sdo, rok;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] pend_l, pend_r;
  bit pend_mute, have_prev;
  int prev_ratio;

  stereo_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .wck_i(wck), .fmt_i2s_i(fmt),
    .clk384_i(c384), .mute_i(mute), .left_i(lin), .right_i(rin),
    .sdo_o(sdo), .ratio_ok_o(rok));

  always #4 clk = ~clk;

  function automatic bit allowed(bit i2s, bit s384, int len);
    if (len == 64) return 1;
    if (len == 48 && s384) return 1;
    if (len == 32 && !i2s) return 1;
    return 0;
  endfunction

  function automatic bit want_bit(bit i2s, int slot, logic [15:0] w);
    int idx;
    idx = i2s ? 16 - slot : 15 - slot;
    if (idx < 0 || idx > 15) return 0;
    if (i2s && slot == 0) return 0;
    return w[idx];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit i2s, bit s384);
    rst_n = 0; bck = 1; wck = 0; mute = 0; fmt = i2s; c384 = s384;
    pend_l = 16'h0; pend_r = 16'h0; lin = 0; rin = 0; pend_mute = 0;
    have_prev = 0; prev_ratio = 0;
    repeat (5) @(negedge clk);
    check(sdo == 1'b0, "R9 sdo in reset", sdo, 0);
    check(rok == 1'b0, "R9 ratio_ok in reset", rok, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(sdo == 1'b0 && rok == 1'b0, "R9 after reset", {sdo, rok}, 0);
  endtask

  // One frame. mr: mute for right half; nl/nr/nm: values for the next frame.
  task automatic run_frame(int ratio, bit mr, logic [15:0] nl, logic [15:0] nr,
                           bit nm, bit chk);
    int half;
    bit okx, zl, zr, lvl_left;
    logic [15:0] el, er;
    half = ratio / 2;
    el = pend_l; er = pend_r;
    okx = have_prev && allowed(fmt, c384, prev_ratio);
    zl = pend_mute || !okx;
    zr = mr || !okx;
    lvl_left = !fmt;
    for (int j = 0; j < ratio; j++) begin
      bit ch, z, e, a0;
      int s;
      logic [15:0] w;
      bck = 0;
      wck = (j < half) ? lvl_left : !lvl_left;
      if (j == 2) mute = mr;
      if (j == 3) begin lin = 16'($urandom); rin = 16'($urandom); end
      if (j == half + 2) mute = nm;
      if (j == ratio - 3) begin lin = nl; rin = nr; end
      repeat (HALF_BCK) @(negedge clk);
      bck = 1;
      @(negedge clk);
      a0 = sdo;
      repeat (4) @(negedge clk);
      ch = (j >= half);
      s = ch ? j - half : j;
      w = ch ? er : el;
      z = ch ? zr : zl;
      e = z ? 0 : want_bit(fmt, s, w);
      if (chk) begin
        string tag;
        if (z) tag = okx ? "R7 mute" : "R6 bad frame";
        else if (want_bit(fmt, s, 16'hFFFF)) tag = fmt ? "R2 R8 i2s data" : "R1 R8 lj data";
        else tag = "R3 padding";
        check(sdo == e, tag, sdo, e);
        check(a0 == sdo, "R4 stable while bck high", a0, sdo);
        if (j == 0 || j == half) check(rok == okx, "R5 ratio flag", rok, okx);
      end
      repeat (HALF_BCK - 5) @(negedge clk);
    end
    pend_l = nl; pend_r = nr; pend_mute = nm;
    prev_ratio = ratio; have_prev = 1;
  endtask

  task automatic warmup(int ratio);
    run_frame(ratio, 0, 16'hA5C3, 16'h3C5A, 0, 0);
    run_frame(ratio, 0, 16'hA5C3, 16'h3C5A, 0, 0);
  endtask

  task automatic random_frames(int n, int r0, int r1, int r2);
    for (int k = 0; k < n; k++) begin
      int pick, r;
      pick = int'($urandom % 3);
      r = (pick == 0) ? r0 : (pick == 1) ? r1 : r2;
      run_frame(r, ($urandom % 4) == 0, 16'($urandom), 16'($urandom),
                ($urandom % 4) == 0, 1);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // Left-justified, 256x system clock
    do_reset(0, 0);
    warmup(64);
    run_frame(64, 0, 16'h0001, 16'h8000, 0, 1);
    run_frame(64, 0, 16'hFFFF, 16'h0000, 0, 1);
    run_frame(32, 1, 16'h1234, 16'hBEEF, 1, 1);   // R7 mute both halves
    run_frame(32, 0, 16'h5555, 16'hAAAA, 0, 1);
    run_frame(48, 0, 16'h7777, 16'h1111, 0, 1);   // R5 48 without 384x: bad
    run_frame(64, 0, 16'h2468, 16'h1357, 0, 1);   // R6 forced zero
    run_frame(64, 0, 16'hC001, 16'h8003, 0, 1);   // R6 recovered
    random_frames(6, 64, 32, 64);
    // Left-justified, 384x system clock
    do_reset(0, 1);
    warmup(48);
    random_frames(6, 48, 64, 32);
    // I2S, 384x system clock
    do_reset(1, 1);
    warmup(64);
    run_frame(64, 0, 16'h8001, 16'h4002, 0, 1);
    run_frame(48, 0, 16'hF0F0, 16'h0F0F, 0, 1);
    run_frame(32, 0, 16'h1111, 16'h2222, 0, 1);   // R5 32 in I2S: bad
    run_frame(64, 0, 16'h3333, 16'h4444, 0, 1);   // R6 forced zero
    run_frame(48, 0, 16'h0000, 16'h0000, 0, 1);
    random_frames(6, 64, 48, 64);
    // I2S, 256x system clock: 48 not allowed
    do_reset(1, 0);
    warmup(64);
    run_frame(48, 0, 16'h9999, 16'h6666, 0, 1);
    run_frame(64, 0, 16'hABCD, 16'hDCBA, 0, 1);
    run_frame(64, 0, 16'h0F0F, 16'hF00F, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule